// File: doc/BRIEF.md
# Serial Five-Write Register Loader

This block holds a small bank of narrow configuration registers that a CPU fills one data bit per bus write. Every non-reset write carries a single payload bit in data bit 0. Successive bits are packed least-significant first into a shift value. The write that supplies the last bit moves the packed value into the register chosen by the two select bits that come with that write. A write with data bit 7 set abandons any partial value and forces two mode bits of register 0 high. The other bits of register 0 and the other registers are left as they are.

Bus writes that follow the previous write too closely are dropped. A small hold-off counter reloads on every write, whether that write is accepted or dropped, and counts down once per CPU cycle. The CPU cycle is marked by a clock enable. A non-reset write lands only when the counter has run out. A reset write always lands. One cycle after any register changes, a one-cycle strobe and the index of that register are presented for the logic that maps banks from these registers.

There are two state machines. The hold-off machine has the states FIL_OPEN and FIL_HOLD. Any write moves it to FIL_HOLD and reloads the counter. In FIL_HOLD, a CPU cycle with no write decrements the counter. When the counter leaves 1, the machine returns to FIL_OPEN. The collection machine has the states SH_EMPTY and SH_PARTIAL. An accepted bit moves it from SH_EMPTY to SH_PARTIAL. The final bit moves it from SH_PARTIAL back to SH_EMPTY and commits the value. A reset write sends it to SH_EMPTY from either state.

Top module: `serial_reg_loader`

## Requirements
- R1: After the asynchronous reset, register 0 reads 0x0C, registers 1 to 3 read 0, no bits are pending and upd_pulse is low.
- R2: Five accepted non-reset writes form a 5-bit value. The first write supplies bit 0 and the fifth supplies bit 4. The value is stored in the register selected by wr_sel on the fifth write, and that register appears at reg_q[5*i +: 5]. reg_q shows the new value from the clock edge of the fifth write.
- R3: A non-reset write uses only wr_data bit 0. Data bits 1 to 6 have no effect.
- R4: A write with wr_data bit 7 set discards all pending bits and ORs 0x0C into register 0. It leaves bits 0, 1 and 4 of register 0 and registers 1 to 3 unchanged.
- R5: A reset write takes effect even while the hold-off counter is running.
- R6: After a write in CPU cycle n, non-reset writes in CPU cycles n+1 and n+2 are dropped. A non-reset write in cycle n+3 or later, with no write in between, is accepted.
- R7: A dropped write still restarts the hold-off period, so a chain of closely spaced writes keeps dropping.
- R8: A write counts only when cpu_ce is high. Clock cycles with cpu_ce low neither deliver writes nor advance the hold-off counter.
- R9: Every register change is followed, one cycle later, by exactly one cycle of upd_pulse with upd_idx naming the register. A reset write reports index 0.
- R10: After a commit or a reset write, the next accepted bit is bit 0 of a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ce | input | 1 | High for one clock per CPU cycle |
| wr_en | input | 1 | CPU write strobe, qualified by cpu_ce |
| wr_sel | input | 2 | Register select (CPU address bits 14:13) |
| wr_data | input | 8 | CPU write data; bit 7 marks a reset write, bit 0 is the payload bit |
| reg_q | output | 20 | The four 5-bit registers packed, register i at bits 5*i+4 to 5*i |
| upd_pulse | output | 1 | One-cycle strobe after a register changes |
| upd_idx | output | 2 | Index of the register that changed |

## Verification
Writes spaced three CPU cycles apart check that bits pack least-significant first into the register chosen on the last write. The bench repeats this with the select changing partway through a sequence, and with noise on data bits 1 to 6, to show that only the final select and only bit 0 matter. Writes one and two cycles after a previous write carry bit values that would change the result if they were accepted, which exposes any hold-off counter that is too short, fails to reload, or blocks reset writes. Stretches with cpu_ce low separate hold-off counted in clock cycles from hold-off counted in CPU cycles. Reset writes placed in the middle of a sequence show that pending bits are discarded and that the OR leaves the other bits of register 0 alone.

// File: rtl/srl_pkg.sv
`timescale 1ns/1ps
package srl_pkg;

    typedef enum logic {
        FIL_OPEN = 1'b0,
        FIL_HOLD = 1'b1
    } filt_state_e;

    typedef enum logic {
        SH_EMPTY   = 1'b0,
        SH_PARTIAL = 1'b1
    } shift_state_e;

endpackage

// File: rtl/srl_write_filter.sv
`timescale 1ns/1ps
module srl_write_filter #(
    parameter int FILTER_LOAD = 2,
    localparam int CW = $clog2(FILTER_LOAD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_ce,
    input  logic          wr_fire,
    output logic          gate_open,
    output logic [CW-1:0] hold_cnt
);
    import srl_pkg::*;

    filt_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FIL_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (wr_fire) begin
            state_d = FIL_HOLD;
            cnt_d   = CW'(FILTER_LOAD);
        end else if (cpu_ce) begin
            unique case (state_q)
                FIL_OPEN: begin
                    cnt_d = '0;
                end
                FIL_HOLD: begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q <= CW'(1)) begin
                        state_d = FIL_OPEN;
                        cnt_d   = '0;
                    end
                end
            endcase
        end
    end

    always_comb begin
        gate_open = (state_q == FIL_OPEN);
        hold_cnt  = cnt_q;
    end

endmodule

// File: rtl/srl_shift_engine.sv
`timescale 1ns/1ps
module srl_shift_engine #(
    parameter int REG_W = 5,
    parameter int IDX_W = 2,
    localparam int CNT_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_wr,
    input  logic             clr,
    input  logic             bit_in,
    input  logic [IDX_W-1:0] idx_in,
    output logic             commit,
    output logic [REG_W-1:0] commit_val,
    output logic [IDX_W-1:0] commit_idx,
    output logic [CNT_W-1:0] fill_cnt
);
    import srl_pkg::*;

    shift_state_e     state_q, state_d;
    logic [REG_W-1:0] sh_q, sh_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [REG_W-1:0] placed;
    logic             last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_EMPTY;
            sh_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        placed   = REG_W'(bit_in) << cnt_q;
        last_bit = (cnt_q == CNT_W'(REG_W - 1));
        state_d  = state_q;
        sh_d     = sh_q;
        cnt_d    = cnt_q;
        if (clr) begin
            state_d = SH_EMPTY;
            sh_d    = '0;
            cnt_d   = '0;
        end else if (bit_wr) begin
            unique case (state_q)
                SH_EMPTY: begin
                    state_d = SH_PARTIAL;
                    sh_d    = placed;
                    cnt_d   = CNT_W'(1);
                end
                SH_PARTIAL: begin
                    if (last_bit) begin
                        state_d = SH_EMPTY;
                        sh_d    = '0;
                        cnt_d   = '0;
                    end else begin
                        sh_d  = sh_q | placed;
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        commit     = bit_wr && !clr && (state_q == SH_PARTIAL) && last_bit;
        commit_val = sh_q | placed;
        commit_idx = idx_in;
        fill_cnt   = cnt_q;
    end

endmodule

// File: rtl/srl_reg_bank.sv
`timescale 1ns/1ps
module srl_reg_bank #(
    parameter int               REG_W    = 5,
    parameter int               NUM_REGS = 4,
    parameter logic [REG_W-1:0] INIT0    = 5'h0C,
    parameter logic [REG_W-1:0] FORCE0   = 5'h0C,
    localparam int              IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  logic [IDX_W-1:0]          commit_idx,
    input  logic [REG_W-1:0]          commit_val,
    input  logic                      force_wr,
    output logic [NUM_REGS*REG_W-1:0] reg_q,
    output logic                      upd_pulse,
    output logic [IDX_W-1:0]          upd_idx
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [REG_W-1:0] RST_V = (g == 0) ? INIT0 : '0;
        logic [REG_W-1:0] r_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= RST_V;
            end else if (commit && commit_idx == IDX_W'(g)) begin
                r_q <= commit_val;
            end else if (force_wr && g == 0) begin
                r_q <= r_q | FORCE0;
            end
        end

        assign reg_q[g*REG_W +: REG_W] = r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_pulse <= 1'b0;
            upd_idx   <= '0;
        end else begin
            upd_pulse <= commit || force_wr;
            upd_idx   <= force_wr ? '0 : commit_idx;
        end
    end

endmodule

// File: rtl/serial_reg_loader.sv
`timescale 1ns/1ps
module serial_reg_loader #(
    parameter int REG_W       = 5,
    parameter int NUM_REGS    = 4,
    parameter int DATA_W      = 8,
    parameter int FILTER_LOAD = 2,
    localparam int IDX_W = $clog2(NUM_REGS),
    localparam int CNT_W = $clog2(REG_W),
    localparam int FW    = $clog2(FILTER_LOAD + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_ce,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_REGS*REG_W-1:0] reg_q,
    output logic                      upd_pulse,
    output logic [IDX_W-1:0]          upd_idx
);

    localparam logic [REG_W-1:0] MODE_BITS = REG_W'(5'h0C);

    logic             wr_fire;
    logic             is_force;
    logic             gate_open;
    logic             bit_wr;
    logic             commit;
    logic [REG_W-1:0] commit_val;
    logic [IDX_W-1:0] commit_idx;
    logic [CNT_W-1:0] fill_cnt;
    logic [FW-1:0]    filt_cnt;
    logic             unused_data_bits;

    assign unused_data_bits = ^wr_data[DATA_W-2:1];

    assign wr_fire  = cpu_ce && wr_en;
    assign is_force = wr_fire && wr_data[DATA_W-1];
    assign bit_wr   = wr_fire && !wr_data[DATA_W-1] && gate_open;

    srl_write_filter #(.FILTER_LOAD(FILTER_LOAD)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_ce    (cpu_ce),
        .wr_fire   (wr_fire),
        .gate_open (gate_open),
        .hold_cnt  (filt_cnt)
    );

    srl_shift_engine #(.REG_W(REG_W), .IDX_W(IDX_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_wr     (bit_wr),
        .clr        (is_force),
        .bit_in     (wr_data[0]),
        .idx_in     (wr_sel),
        .commit     (commit),
        .commit_val (commit_val),
        .commit_idx (commit_idx),
        .fill_cnt   (fill_cnt)
    );

    srl_reg_bank #(
        .REG_W    (REG_W),
        .NUM_REGS (NUM_REGS),
        .INIT0    (MODE_BITS),
        .FORCE0   (MODE_BITS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_idx (commit_idx),
        .commit_val (commit_val),
        .force_wr   (is_force),
        .reg_q      (reg_q),
        .upd_pulse  (upd_pulse),
        .upd_idx    (upd_idx)
    );

endmodule

// File: rtl/srl_chk.sv
`timescale 1ns/1ps
module srl_chk #(
    parameter int REG_W       = 5,
    parameter int NUM_REGS    = 4,
    parameter int FILTER_LOAD = 2,
    localparam int IDX_W = $clog2(NUM_REGS),
    localparam int CNT_W = $clog2(REG_W),
    localparam int FW    = $clog2(FILTER_LOAD + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cpu_ce,
    input logic                      wr_en,
    input logic                      force_bit,
    input logic [NUM_REGS*REG_W-1:0] reg_q,
    input logic                      upd_pulse,
    input logic [IDX_W-1:0]          upd_idx,
    input logic [CNT_W-1:0]          fill_cnt,
    input logic [FW-1:0]             filt_cnt
);

    // R6
    hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && wr_en && !force_bit && filt_cnt != '0)
            |=> ($stable(fill_cnt) && $stable(reg_q)));

    // R4
    force_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && wr_en && force_bit)
            |=> (fill_cnt == '0 && reg_q[3:2] == 2'b11 && upd_pulse && upd_idx == '0));

    // R8
    idle_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ce) |=> ($stable(reg_q) && $stable(fill_cnt) && $stable(filt_cnt)));

    // R9
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(cpu_ce && wr_en));

    // R7
    hold_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && wr_en) |=> (filt_cnt == FW'(FILTER_LOAD)));

    // R2
    commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && upd_idx != '0) |-> ($past(fill_cnt) == CNT_W'(REG_W - 1)));

endmodule

bind serial_reg_loader srl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ce    (cpu_ce),
    .wr_en     (wr_en),
    .force_bit (wr_data[7]),
    .reg_q     (reg_q),
    .upd_pulse (upd_pulse),
    .upd_idx   (upd_idx),
    .fill_cnt  (fill_cnt),
    .filt_cnt  (filt_cnt)
);

// File: tb/serial_reg_loader_test.sv
`timescale 1ns/1ps
module serial_reg_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_ce = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [19:0] reg_q;
    logic        upd_pulse;
    logic [1:0]  upd_idx;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string cur_tag = "R1";

    logic [4:0] m_reg [4];
    logic [4:0] m_sh;
    int         m_cnt;
    int         m_filt;
    logic [6:0] exp_q [$];

    always #2 clk = ~clk;

    serial_reg_loader uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_ce    (cpu_ce),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .reg_q     (reg_q),
        .upd_pulse (upd_pulse),
        .upd_idx   (upd_idx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [19:0] model_bank();
        return {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
    endfunction

    // Driver: one clock cycle of stimulus, model update, expected pushes.
    task automatic tick(input bit ce, input bit we, input logic [1:0] a, input logic [7:0] d);
        cpu_ce  = ce;
        wr_en   = we;
        wr_sel  = a;
        wr_data = d;
        if (ce && we) begin
            if (d[7]) begin
                m_sh = '0;
                m_cnt = 0;
                m_reg[0] = m_reg[0] | 5'h0C;
                exp_q.push_back({2'd0, m_reg[0]});
            end else if (m_filt == 0) begin
                m_sh[m_cnt] = d[0];
                m_cnt++;
                if (m_cnt == 5) begin
                    m_reg[a] = m_sh;
                    exp_q.push_back({a, m_sh});
                    m_sh = '0;
                    m_cnt = 0;
                end
            end
            m_filt = 2;
        end else if (ce && m_filt > 0) begin
            m_filt--;
        end
        @(negedge clk);
        check(cur_tag, 32'(reg_q), 32'(model_bank()));
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        tick(1, 1, a, d);
        tick(1, 0, 2'd0, 8'h00);
        tick(1, 0, 2'd0, 8'h00);
    endtask

    task automatic load5(input logic [1:0] a, input logic [4:0] v, input logic [7:0] noise);
        for (int i = 0; i < 5; i++) wr(a, (noise & 8'h7E) | 8'(v[i]));
    endtask

    // Monitor: pop and compare each update strobe.
    always @(negedge clk) begin
        if (rst_n && upd_pulse) begin
            if (exp_q.size() == 0) begin
                check("R9", 32'(upd_idx), 32'hFFFF_FFFF);
            end else begin
                logic [6:0] e;
                e = exp_q.pop_front();
                check("R9", 32'(upd_idx), 32'(e[6:5]));
                check("R2", 32'(reg_q[5*upd_idx +: 5]), 32'(e[4:0]));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        m_reg[0] = 5'h0C; m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
        m_sh = '0; m_cnt = 0; m_filt = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", 32'(reg_q), 32'h0000C);
        check("R1", 32'(upd_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(reg_q), 32'h0000C);

        // R2 plain load into register 1, LSB first
        cur_tag = "R2";
        load5(2'd1, 5'h15, 8'h00);
        check("R2", 32'(reg_q[9:5]), 32'h15);
        load5(2'd0, 5'h13, 8'h00);

        // R3 noise on bits 1..6
        cur_tag = "R3";
        load5(2'd2, 5'h0A, 8'h7E);
        check("R3", 32'(reg_q[14:10]), 32'h0A);

        // R2 select changes mid-sequence: fifth write decides
        cur_tag = "R2";
        for (int i = 0; i < 4; i++) wr(2'd0, 8'(i & 1));
        wr(2'd3, 8'h01);
        check("R2", 32'(reg_q[19:15]), 32'h1A);

        // R4 / R10 reset write mid-sequence
        cur_tag = "R4";
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h80);
        check("R4", 32'(reg_q[4:0]), 32'h1F);
        cur_tag = "R10";
        load5(2'd1, 5'h06, 8'h00);
        check("R10", 32'(reg_q[9:5]), 32'h06);

        // R6 / R7 closely spaced writes dropped
        cur_tag = "R6";
        tick(1, 1, 2'd2, 8'h00);
        tick(1, 1, 2'd2, 8'h01);
        tick(1, 0, 2'd0, 8'h00);
        tick(1, 1, 2'd2, 8'h01);
        cur_tag = "R7";
        tick(1, 1, 2'd2, 8'h01);
        tick(1, 0, 2'd0, 8'h00);
        tick(1, 0, 2'd0, 8'h00);
        cur_tag = "R6";
        for (int i = 0; i < 4; i++) wr(2'd2, 8'h00);
        check("R6", 32'(reg_q[14:10]), 32'h00);

        // R5 reset write while hold-off is running
        cur_tag = "R5";
        wr(2'd0, 8'h01);
        tick(1, 1, 2'd1, 8'h01);
        tick(1, 1, 2'd1, 8'h80);
        tick(1, 1, 2'd1, 8'h01);
        tick(1, 0, 2'd0, 8'h00);
        tick(1, 0, 2'd0, 8'h00);
        load5(2'd1, 5'h19, 8'h00);
        check("R5", 32'(reg_q[9:5]), 32'h19);

        // R8 cpu_ce gating of writes and hold-off
        cur_tag = "R8";
        tick(1, 1, 2'd3, 8'h01);
        for (int i = 0; i < 4; i++) tick(0, 1, 2'd3, 8'h01);
        for (int i = 0; i < 4; i++) tick(0, 0, 2'd3, 8'h00);
        tick(1, 1, 2'd3, 8'h01);
        tick(1, 0, 2'd0, 8'h00);
        tick(1, 0, 2'd0, 8'h00);
        for (int i = 0; i < 4; i++) wr(2'd3, 8'h00);
        check("R8", 32'(reg_q[19:15]), 32'h01);

        // R9 drain
        tick(1, 0, 2'd0, 8'h00);
        tick(1, 0, 2'd0, 8'h00);
        check("R9", 32'(exp_q.size()), 0);
        check("R9", 32'(upd_pulse), 0);
        finish_run();
    end

endmodule